// File: doc/BRIEF.md
# AES Engine Control Register Front End

This block is the software-facing control window of an AES engine. A 32-bit, word-aligned register port lets software choose a key source, set the cipher direction and issue commands. The block turns those commands into pins on the engine: a key-load transfer, a start pulse, an engine reset and a key-zero pulse. It holds a 256-bit user key that software can write but never read back, and a 128-bit IV that only the engine's feedback path can change. It also keeps six 256-bit device-key slots, with a select register that picks the one used as the device key source.

A key load is handled by a small state machine, `aes_key_xfer`. In `XF_IDLE` it waits for a load command. With a supported source it takes a snapshot of the key and moves to `XF_SEND`. With an unsupported source it moves to `XF_REJECT`, which lasts one cycle and raises the error flag. In `XF_SEND` it presents one word per cycle with its index, and it only moves to the next word when the engine signals ready. After word 7 it spends one cycle in `XF_FINISH`, which marks the key as loaded, and then returns to `XF_IDLE`. A soft reset or an engine key-zero command sends `XF_SEND` straight back to `XF_IDLE`. `XF_FINISH` and `XF_REJECT` always return to `XF_IDLE` on the next cycle.

Word index map (byte address divided by 4):

| Index | Register |
|---|---|
| 0 | status |
| 1 | key source |
| 2 | load |
| 3 | start |
| 4 | soft reset |
| 5 | key clear |
| 6 | config |
| 7 | feedback control |
| 8–15 | user key |
| 16–19 | IV |

Unaligned or unmapped accesses are ignored and read as zero.

Top module: `aes_ctl_regs`

## Requirements
- R1: The status word holds these bits:
  - bit 0: busy
  - bit 1: ready
  - bit 2: done
  - bit 3: tag pass
  - bit 4: key loaded
  - bit 5: always 0
  - bit 6: source error
  - bit 8: engine key zeroed
  - bit 9: user key is all zero
  - bits 10 and 11: always 1
  - all other bits: 0

  With the engine inputs low and its key-zeroed input high, the status word reads 0xF00 after reset. Writes to the status word are ignored.
- R2: The eight user-key words (byte addresses 0x20–0x3C) can be written but always read as zero.
- R3: The IV words (0x40–0x4C) ignore bus writes. They load `fb_iv` (word 0 = bits 31:0) when `fb_valid` is high and feedback-control bit 1 is set.
- R4: A nonzero write to load (0x08) with key source 0 sends the user key as words 0 to 7 on `eng_key_word`/`eng_key_idx`. The transfer moves one word per cycle while `eng_ready` is high and holds the current word while it is low. Status bit 4 is set after the last word.
- R5: Key source 1 sends the device slot chosen by `dk_sel_code`: 0 battery RAM, 1 eFuse, 2 boot, 3 operational, 4 family, 5 PUF. Codes 6 and 7 deselect every slot, and all-zero words are then sent.
- R6: A load with key source 2 to 15 sends nothing and sets `key_src_err` and status bit 6. The flag is cleared by the next accepted load or by a soft reset.
- R7: A load command that arrives while a transfer is in progress is ignored.
- R8: A nonzero write to start (0x0C) gives a one-cycle `eng_start` pulse, with `eng_encrypt` taken from config bit 0.
- R9: Key clear (0x14) has two bits:
  - Bit 0 pulses `eng_key_zero`, clears key-loaded and aborts a transfer.
  - Bit 1 zeroes all user-key words.

  Both bits clear themselves and read as zero.
- R10: A nonzero write to soft reset (0x10), when `eng_reset` is not already high, does all of the following:
  - restores every register to its reset value
  - pulses `eng_reset` for one cycle
  - clears key-loaded and the source error
  - aborts a transfer
- R11: Key source (4 bits), config (bit 0) and feedback control (2 bits) read back what was written. The load, start and soft-reset registers always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| eng_busy | input | 1 | Engine busy |
| eng_done | input | 1 | Engine done |
| eng_ready | input | 1 | Engine ready; also paces key words |
| eng_tag_pass | input | 1 | Authentication tag matched |
| eng_key_zeroed | input | 1 | Engine key register is clear |
| eng_key_valid | output | 1 | Key word present |
| eng_key_idx | output | 3 | Key word index |
| eng_key_word | output | 32 | Key word |
| eng_start | output | 1 | Start-message pulse |
| eng_encrypt | output | 1 | Direction latched with start, 1 = encrypt |
| eng_key_zero | output | 1 | Zero-engine-key pulse |
| eng_reset | output | 1 | Engine reset pulse |
| fb_valid | input | 1 | Feedback IV strobe |
| fb_iv | input | 128 | Feedback IV value |
| dk_wr | input | 1 | Device-key slot write |
| dk_wr_slot | input | 3 | Slot written |
| dk_wr_key | input | 256 | Slot contents |
| dk_sel_wr | input | 1 | Device-key select strobe |
| dk_sel_code | input | 3 | Select code |
| key_src_err | output | 1 | Unsupported key source flag |

## Verification
The hardest case to reach is a command that lands while `XF_SEND` is stalled halfway through a transfer. The bench creates it by holding `eng_ready` low before a load, so the state machine stays on word 0. It then issues a second load, or a soft reset, into that stall. When ready returns, the scoreboard confirms that exactly one key, or no key at all, crosses the pins. Device-slot selection and the deselect codes are reached by writing slots through the side port before selecting source 1.

// File: rtl/aes_ctl_pkg.sv
package aes_ctl_pkg;
    localparam int WIX_STATUS = 0;
    localparam int WIX_KSRC   = 1;
    localparam int WIX_LOAD   = 2;
    localparam int WIX_START  = 3;
    localparam int WIX_SRST   = 4;
    localparam int WIX_KCLR   = 5;
    localparam int WIX_CFG    = 6;
    localparam int WIX_FBCTL  = 7;
    localparam int WIX_UKEY0  = 8;
    localparam int WIX_IV0    = 16;

    localparam logic [3:0] KSRC_USER = 4'd0;
    localparam logic [3:0] KSRC_DEV  = 4'd1;

    localparam int ST_BUSY  = 0;
    localparam int ST_READY = 1;
    localparam int ST_DONE  = 2;
    localparam int ST_TAG   = 3;
    localparam int ST_KLOAD = 4;
    localparam int ST_ERR   = 6;
    localparam int ST_EKZ   = 8;
    localparam int ST_UKZ   = 9;
    localparam int ST_BKZ   = 10;
    localparam int ST_OKZ   = 11;

    typedef enum logic [1:0] {
        XF_IDLE,
        XF_SEND,
        XF_FINISH,
        XF_REJECT
    } xfer_state_t;
endpackage

// File: rtl/aes_devkey_bank.sv
module aes_devkey_bank #(
    parameter int NSLOT = 6,
    parameter int KEYW  = 256,
    parameter int SELW  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [SELW-1:0] wr_slot,
    input  logic [KEYW-1:0] wr_key,
    input  logic            sel_en,
    input  logic [SELW-1:0] sel_code,
    output logic [KEYW-1:0] key_out
);
    logic [KEYW-1:0] slot_bus [NSLOT];
    logic [SELW-1:0] sel_q;
    logic            sel_valid_q;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        logic [KEYW-1:0] slot_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_q <= '0;
            else if (wr_en && wr_slot == SELW'(g))
                slot_q <= wr_key;
        end
        assign slot_bus[g] = slot_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q       <= '0;
            sel_valid_q <= 1'b0;
        end else if (sel_en) begin
            sel_q       <= sel_code;
            sel_valid_q <= (int'(sel_code) < NSLOT);
        end
    end

    always_comb begin
        key_out = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (sel_valid_q && sel_q == SELW'(i))
                key_out = slot_bus[i];
        end
    end
endmodule

// File: rtl/aes_key_xfer.sv
module aes_key_xfer
    import aes_ctl_pkg::*;
#(
    parameter int KEY_WORDS = 8,
    parameter int DW        = 32,
    localparam int IXW      = $clog2(KEY_WORDS),
    localparam int KB       = KEY_WORDS * DW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_cmd,
    input  logic [3:0]     src,
    input  logic [KB-1:0]  user_key,
    input  logic [KB-1:0]  dev_key,
    input  logic           abort,
    input  logic           err_clr,
    input  logic           eng_ready,
    output logic           key_valid,
    output logic [IXW-1:0] key_idx,
    output logic [DW-1:0]  key_word,
    output logic           load_done,
    output logic           src_err
);
    xfer_state_t    state_q, state_d;
    logic [KB-1:0]  snap_q;
    logic [IXW-1:0] idx_q;
    logic           src_ok, accept, last;

    assign src_ok = (src == KSRC_USER) || (src == KSRC_DEV);
    assign accept = (state_q == XF_IDLE) && load_cmd && src_ok && !abort;
    assign last   = (idx_q == IXW'(KEY_WORDS - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XF_IDLE: begin
                if (load_cmd && !abort)
                    state_d = src_ok ? XF_SEND : XF_REJECT;
            end
            XF_SEND: begin
                if (abort)
                    state_d = XF_IDLE;
                else if (eng_ready && last)
                    state_d = XF_FINISH;
            end
            XF_FINISH: state_d = XF_IDLE;
            XF_REJECT: state_d = XF_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= XF_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            snap_q <= '0;
        end else if (accept) begin
            idx_q  <= '0;
            snap_q <= (src == KSRC_USER) ? user_key : dev_key;
        end else if (state_q == XF_SEND && eng_ready && !last) begin
            idx_q  <= idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            src_err <= 1'b0;
        else if (err_clr || accept)
            src_err <= 1'b0;
        else if (state_q == XF_REJECT)
            src_err <= 1'b1;
    end

    always_comb begin
        key_valid = 1'b0;
        load_done = 1'b0;
        unique case (state_q)
            XF_IDLE:   ;
            XF_SEND:   key_valid = 1'b1;
            XF_FINISH: load_done = 1'b1;
            XF_REJECT: ;
        endcase
        key_idx  = idx_q;
        key_word = snap_q[idx_q*DW +: DW];
    end
endmodule

// File: rtl/aes_ctl_regfile.sv
module aes_ctl_regfile
    import aes_ctl_pkg::*;
#(
    parameter int AW        = 8,
    parameter int DW        = 32,
    parameter int KEY_WORDS = 8,
    parameter int IV_WORDS  = 4,
    localparam int IXW      = AW - 2,
    localparam int KB       = KEY_WORDS * DW,
    localparam int IVB      = IV_WORDS * DW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic           rd_en,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata,
    input  logic           in_reset,
    input  logic           fb_valid,
    input  logic [IVB-1:0] fb_iv,
    input  logic [DW-1:0]  status_word,
    output logic [3:0]     key_src,
    output logic           cfg_enc,
    output logic [KB-1:0]  user_key,
    output logic           load_cmd,
    output logic           start_cmd,
    output logic           srst_cmd,
    output logic           kzero_cmd,
    output logic           kup_zero_cmd
);
    logic [IXW-1:0] wix;
    logic           aligned, wr_ok, wdata_nz;
    logic [1:0]     fbctl_q;
    logic [DW-1:0]  iv_bus [IV_WORDS];

    assign wix      = addr[AW-1:2];
    assign aligned  = (addr[1:0] == 2'b00);
    assign wr_ok    = wr_en && aligned;
    assign wdata_nz = (wdata != '0);

    assign load_cmd     = wr_ok && wix == IXW'(WIX_LOAD)  && wdata_nz;
    assign start_cmd    = wr_ok && wix == IXW'(WIX_START) && wdata_nz;
    assign srst_cmd     = wr_ok && wix == IXW'(WIX_SRST)  && wdata_nz && !in_reset;
    assign kzero_cmd    = wr_ok && wix == IXW'(WIX_KCLR)  && wdata[0];
    assign kup_zero_cmd = wr_ok && wix == IXW'(WIX_KCLR)  && wdata[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_src <= '0;
            cfg_enc <= 1'b0;
            fbctl_q <= '0;
        end else if (srst_cmd) begin
            key_src <= '0;
            cfg_enc <= 1'b0;
            fbctl_q <= '0;
        end else if (wr_ok) begin
            if (wix == IXW'(WIX_KSRC))  key_src <= wdata[3:0];
            if (wix == IXW'(WIX_CFG))   cfg_enc <= wdata[0];
            if (wix == IXW'(WIX_FBCTL)) fbctl_q <= wdata[1:0];
        end
    end

    for (genvar g = 0; g < KEY_WORDS; g++) begin : g_ukey
        logic [DW-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word_q <= '0;
            else if (srst_cmd || kup_zero_cmd)
                word_q <= '0;
            else if (wr_ok && wix == IXW'(WIX_UKEY0 + g))
                word_q <= wdata;
        end
        assign user_key[g*DW +: DW] = word_q;
    end

    for (genvar g = 0; g < IV_WORDS; g++) begin : g_iv
        logic [DW-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word_q <= '0;
            else if (srst_cmd)
                word_q <= '0;
            else if (fb_valid && fbctl_q[1])
                word_q <= fb_iv[g*DW +: DW];
        end
        assign iv_bus[g] = word_q;
    end

    always_comb begin
        rdata = '0;
        if (rd_en && aligned) begin
            if (wix == IXW'(WIX_STATUS))
                rdata = status_word;
            else if (wix == IXW'(WIX_KSRC))
                rdata = DW'(key_src);
            else if (wix == IXW'(WIX_CFG))
                rdata = DW'(cfg_enc);
            else if (wix == IXW'(WIX_FBCTL))
                rdata = DW'(fbctl_q);
            for (int i = 0; i < IV_WORDS; i++) begin
                if (wix == IXW'(WIX_IV0 + i))
                    rdata = iv_bus[i];
            end
        end
    end
endmodule

// File: rtl/aes_ctl_regs.sv
module aes_ctl_regs
    import aes_ctl_pkg::*;
#(
    parameter int AW        = 8,
    parameter int DW        = 32,
    parameter int KEY_WORDS = 8,
    parameter int IV_WORDS  = 4,
    parameter int NSLOT     = 6,
    parameter int SELW      = 3,
    localparam int IXW      = $clog2(KEY_WORDS),
    localparam int KB       = KEY_WORDS * DW,
    localparam int IVB      = IV_WORDS * DW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic            eng_busy,
    input  logic            eng_done,
    input  logic            eng_ready,
    input  logic            eng_tag_pass,
    input  logic            eng_key_zeroed,
    output logic            eng_key_valid,
    output logic [IXW-1:0]  eng_key_idx,
    output logic [DW-1:0]   eng_key_word,
    output logic            eng_start,
    output logic            eng_encrypt,
    output logic            eng_key_zero,
    output logic            eng_reset,
    input  logic            fb_valid,
    input  logic [IVB-1:0]  fb_iv,
    input  logic            dk_wr,
    input  logic [SELW-1:0] dk_wr_slot,
    input  logic [KB-1:0]   dk_wr_key,
    input  logic            dk_sel_wr,
    input  logic [SELW-1:0] dk_sel_code,
    output logic            key_src_err
);
    logic [3:0]    key_src;
    logic          cfg_enc;
    logic [KB-1:0] user_key, dev_key;
    logic          load_cmd, start_cmd, srst_cmd, kzero_cmd, kup_zero_cmd;
    logic          load_done, key_loaded;
    logic [DW-1:0] status_word;

    always_comb begin
        status_word           = '0;
        status_word[ST_BUSY]  = eng_busy;
        status_word[ST_READY] = eng_ready;
        status_word[ST_DONE]  = eng_done;
        status_word[ST_TAG]   = eng_tag_pass;
        status_word[ST_KLOAD] = key_loaded;
        status_word[ST_ERR]   = key_src_err;
        status_word[ST_EKZ]   = eng_key_zeroed;
        status_word[ST_UKZ]   = (user_key == '0);
        status_word[ST_BKZ]   = 1'b1;
        status_word[ST_OKZ]   = 1'b1;
    end

    aes_ctl_regfile #(
        .AW(AW), .DW(DW), .KEY_WORDS(KEY_WORDS), .IV_WORDS(IV_WORDS)
    ) i_regfile (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (bus_wr),
        .rd_en        (bus_rd),
        .addr         (bus_addr),
        .wdata        (bus_wdata),
        .rdata        (bus_rdata),
        .in_reset     (eng_reset),
        .fb_valid     (fb_valid),
        .fb_iv        (fb_iv),
        .status_word  (status_word),
        .key_src      (key_src),
        .cfg_enc      (cfg_enc),
        .user_key     (user_key),
        .load_cmd     (load_cmd),
        .start_cmd    (start_cmd),
        .srst_cmd     (srst_cmd),
        .kzero_cmd    (kzero_cmd),
        .kup_zero_cmd (kup_zero_cmd)
    );

    aes_devkey_bank #(
        .NSLOT(NSLOT), .KEYW(KB), .SELW(SELW)
    ) i_devkeys (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (dk_wr),
        .wr_slot  (dk_wr_slot),
        .wr_key   (dk_wr_key),
        .sel_en   (dk_sel_wr),
        .sel_code (dk_sel_code),
        .key_out  (dev_key)
    );

    aes_key_xfer #(
        .KEY_WORDS(KEY_WORDS), .DW(DW)
    ) i_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_cmd  (load_cmd),
        .src       (key_src),
        .user_key  (user_key),
        .dev_key   (dev_key),
        .abort     (srst_cmd | kzero_cmd),
        .err_clr   (srst_cmd),
        .eng_ready (eng_ready),
        .key_valid (eng_key_valid),
        .key_idx   (eng_key_idx),
        .key_word  (eng_key_word),
        .load_done (load_done),
        .src_err   (key_src_err)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_start    <= 1'b0;
            eng_encrypt  <= 1'b0;
            eng_key_zero <= 1'b0;
            eng_reset    <= 1'b0;
        end else begin
            eng_start    <= start_cmd;
            eng_key_zero <= kzero_cmd;
            eng_reset    <= srst_cmd;
            if (start_cmd)
                eng_encrypt <= cfg_enc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            key_loaded <= 1'b0;
        else if (srst_cmd || kzero_cmd)
            key_loaded <= 1'b0;
        else if (load_done)
            key_loaded <= 1'b1;
    end
endmodule

// File: rtl/aes_ctl_checker.sv
module aes_ctl_checker #(
    parameter int AW  = 8,
    parameter int DW  = 32,
    parameter int IXW = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_wr,
    input logic [AW-1:0]  bus_addr,
    input logic [DW-1:0]  bus_wdata,
    input logic           eng_ready,
    input logic           eng_key_valid,
    input logic [IXW-1:0] eng_key_idx,
    input logic [DW-1:0]  eng_key_word,
    input logic           eng_start,
    input logic           eng_reset,
    input logic           key_src_err
);
    logic ctl_wr;
    assign ctl_wr = bus_wr && (bus_addr == AW'(16) || bus_addr == AW'(20));

    AST_START_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> $past(bus_wr && bus_addr == AW'(12) && bus_wdata != '0)); // R8

    AST_FIRST_WORD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_key_valid) |-> eng_key_idx == '0); // R4

    AST_WORD_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_key_valid && eng_ready && eng_key_idx != '1 && !ctl_wr)
        |=> (eng_key_valid && eng_key_idx == $past(eng_key_idx) + 1'b1)); // R4

    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_key_valid && !eng_ready && !ctl_wr)
        |=> (eng_key_valid && $stable(eng_key_idx) && $stable(eng_key_word))); // R4

    AST_ERR_NO_SEND: assert property (@(posedge clk) disable iff (!rst_n)
        key_src_err |-> !eng_key_valid); // R6

    AST_RESET_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_reset |=> !eng_reset); // R10
endmodule

bind aes_ctl_regs aes_ctl_checker #(.AW(AW), .DW(DW), .IXW(IXW)) i_chk (.*);

// File: tb/test_aes_ctl_regs.sv
module test_aes_ctl_regs;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         eng_busy = 0, eng_done = 0, eng_ready = 0, eng_tag_pass = 0, eng_key_zeroed = 1;
    logic         eng_key_valid;
    logic [2:0]   eng_key_idx;
    logic [31:0]  eng_key_word;
    logic         eng_start, eng_encrypt, eng_key_zero, eng_reset;
    logic         fb_valid = 0;
    logic [127:0] fb_iv = '0;
    logic         dk_wr = 0;
    logic [2:0]   dk_wr_slot = '0;
    logic [255:0] dk_wr_key = '0;
    logic         dk_sel_wr = 0;
    logic [2:0]   dk_sel_code = '0;
    logic         key_src_err;

    int n_checks = 0;
    int n_errors = 0;
    bit done_flag = 0;
    logic [34:0] exp_q [$];
    string       tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    aes_ctl_regs i_aes_ctl_regs (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor: pops one expected word per handshake
    always @(negedge clk) begin
        if (rst_n && eng_key_valid && eng_ready) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_errors++;
                $display("FAIL R7 actual=unexpected word idx %0d expected=no transfer", eng_key_idx);
            end else begin
                logic [34:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({eng_key_idx, eng_key_word} !== e) begin
                    n_errors++;
                    $display("FAIL %s actual=%h expected=%h", t, {eng_key_idx, eng_key_word}, e);
                end
            end
        end
    end

    task automatic push_key(input logic [255:0] k, input string t);
        for (int i = 0; i < 8; i++) begin
            exp_q.push_back({3'(i), k[i*32 +: 32]});
            tag_q.push_back(t);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #(CLK_PERIOD/4);
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] stat(input bit ld, input bit err, input bit ukz);
        return 32'h0000_0D00 | (32'(ukz) << 9) | (32'(err) << 6) | (32'(ld) << 4)
             | (32'(eng_ready) << 1);
    endfunction

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0]  v;
        logic [255:0] ukey, slot3, slot0;
        for (int i = 0; i < 8; i++) ukey[i*32 +: 32] = 32'hA000_0000 + 32'(i) * 32'h1111;
        slot3 = {8{32'h3C3C_0000}} ^ {32'd7, 32'd6, 32'd5, 32'd4, 32'd3, 32'd2, 32'd1, 32'd0};
        slot0 = {4{64'h0123_4567_89AB_CDEF}};

        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        rd(8'h00, v); chk("R1 reset status", v, 32'h0000_0F00);
        chk("R1 no key at reset", 32'(eng_key_valid), 0);
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, v); chk("R1 status write ignored", v, 32'h0000_0F00);
        eng_ready = 1; eng_busy = 1; eng_done = 1; eng_tag_pass = 1;
        rd(8'h00, v); chk("R1 engine bits", v, 32'h0000_0F0F);
        eng_busy = 0; eng_done = 0; eng_tag_pass = 0;

        // R2 user key write-only
        for (int i = 0; i < 8; i++) wr(8'h20 + 8'(4*i), ukey[i*32 +: 32]);
        rd(8'h20, v); chk("R2 key word 0 reads zero", v, 0);
        rd(8'h3C, v); chk("R2 key word 7 reads zero", v, 0);
        rd(8'h00, v); chk("R1 user key nonzero", v, stat(0, 0, 0));

        // R11 readable controls
        wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, v); chk("R11 key source", v, 32'hF);
        wr(8'h18, 32'hFFFF_FFFF); rd(8'h18, v); chk("R11 config", v, 32'h1);
        wr(8'h1C, 32'hFFFF_FFFF); rd(8'h1C, v); chk("R11 feedback ctl", v, 32'h3);
        rd(8'h08, v); chk("R11 load reads zero", v, 0);
        rd(8'h10, v); chk("R11 reset reads zero", v, 0);
        wr(8'h04, 0); wr(8'h18, 0); wr(8'h1C, 0);

        // R4 user key transfer
        push_key(ukey, "R4");
        wr(8'h08, 1);
        wait_cyc(14);
        chk("R4 all words sent", 32'(exp_q.size()), 0);
        rd(8'h00, v); chk("R4 key loaded flag", v, stat(1, 0, 0));

        // R7 stalled transfer, second load ignored
        eng_ready = 0;
        push_key(ukey, "R7");
        wr(8'h08, 1);
        wait_cyc(3);
        chk("R4 hold on stall valid", 32'(eng_key_valid), 1);
        chk("R4 hold on stall idx", 32'(eng_key_idx), 0);
        wr(8'h08, 1);
        eng_ready = 1;
        wait_cyc(14);
        chk("R7 exactly one key", 32'(exp_q.size()), 0);
        chk("R7 transfer ended", 32'(eng_key_valid), 0);

        // R5 device key slots
        @(negedge clk); dk_wr = 1; dk_wr_slot = 3; dk_wr_key = slot3;
        @(negedge clk); dk_wr_slot = 0; dk_wr_key = slot0;
        @(negedge clk); dk_wr = 0; dk_sel_wr = 1; dk_sel_code = 3;
        @(negedge clk); dk_sel_wr = 0;
        wr(8'h04, 1);
        push_key(slot3, "R5 slot 3");
        wr(8'h08, 1); wait_cyc(14);
        @(negedge clk); dk_sel_wr = 1; dk_sel_code = 0;
        @(negedge clk); dk_sel_wr = 0;
        push_key(slot0, "R5 slot 0");
        wr(8'h08, 1); wait_cyc(14);
        @(negedge clk); dk_sel_wr = 1; dk_sel_code = 7;
        @(negedge clk); dk_sel_wr = 0;
        push_key('0, "R5 deselected");
        wr(8'h08, 1); wait_cyc(14);
        chk("R5 all device words sent", 32'(exp_q.size()), 0);

        // R6 unsupported source
        wr(8'h04, 2);
        wr(8'h08, 1); wait_cyc(4);
        chk("R6 error flag", 32'(key_src_err), 1);
        rd(8'h00, v); chk("R6 status error bit", v, stat(1, 1, 0));
        wr(8'h04, 0);
        push_key(ukey, "R6 recovery");
        wr(8'h08, 1); wait_cyc(14);
        chk("R6 error cleared", 32'(key_src_err), 0);

        // R8 start pulse
        wr(8'h18, 1);
        wr(8'h0C, 1);
        chk("R8 start pulse", 32'(eng_start), 1);
        chk("R8 encrypt", 32'(eng_encrypt), 1);
        @(negedge clk); chk("R8 pulse one cycle", 32'(eng_start), 0);
        wr(8'h18, 0);
        wr(8'h0C, 1);
        chk("R8 decrypt", 32'(eng_encrypt), 0);
        wr(8'h0C, 0);
        chk("R8 zero write no pulse", 32'(eng_start), 0);

        // R9 key clear
        wr(8'h14, 1);
        chk("R9 key zero pulse", 32'(eng_key_zero), 1);
        rd(8'h00, v); chk("R9 key loaded cleared", v, stat(0, 0, 0));
        rd(8'h14, v); chk("R9 clear reads zero", v, 0);
        wr(8'h14, 2);
        rd(8'h00, v); chk("R9 user key zeroed", v, stat(0, 0, 1));
        push_key('0, "R9 zeroed key");
        wr(8'h08, 1); wait_cyc(14);

        // R3 IV feedback only
        wr(8'h40, 32'hDEAD_BEEF);
        rd(8'h40, v); chk("R3 IV bus write ignored", v, 0);
        fb_iv = {32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111};
        @(negedge clk); fb_valid = 1; @(negedge clk); fb_valid = 0;
        rd(8'h40, v); chk("R3 IV gated by control", v, 0);
        wr(8'h1C, 2);
        @(negedge clk); fb_valid = 1; @(negedge clk); fb_valid = 0;
        rd(8'h40, v); chk("R3 IV word 0", v, 32'h1111_1111);
        rd(8'h4C, v); chk("R3 IV word 3", v, 32'h4444_4444);

        // R10 soft reset
        wr(8'h24, 32'h55);
        wr(8'h18, 1);
        push_key({192'd0, 32'h55, 32'd0}, "R10 setup");
        wr(8'h08, 1); wait_cyc(14);
        wr(8'h04, 1);
        wr(8'h10, 1);
        chk("R10 engine reset pulse", 32'(eng_reset), 1);
        @(negedge clk); chk("R10 pulse one cycle", 32'(eng_reset), 0);
        rd(8'h04, v); chk("R10 key source restored", v, 0);
        rd(8'h18, v); chk("R10 config restored", v, 0);
        rd(8'h40, v); chk("R10 IV restored", v, 0);
        rd(8'h00, v); chk("R10 status restored", v, stat(0, 0, 1));
        eng_ready = 0;
        wr(8'h08, 1); wait_cyc(2);
        wr(8'h10, 1);
        eng_ready = 1;
        wait_cyc(10);
        chk("R10 transfer aborted", 32'(eng_key_valid), 0);
        chk("R10 queue empty", 32'(exp_q.size()), 0);

        finish_run();
    end
endmodule